// File: doc/BRIEF.md
# Stack push/pop unit

This block carries out stack push and pop operations for a processor whose registers and memory words are all 32 bits wide and whose memory is addressed by word. The stack pointer is not a separate register: it is entry 13 of a 16-entry general register file. That register file sits inside the block, and any entry can be read through a read port for observation.

A push takes an already-resolved 32-bit value. It lowers the stack pointer by one and then writes the value to memory at the new pointer. A pop reads the word at the current pointer, writes it to a chosen register, and raises the pointer by one. Each operation takes two cycles. `busy` is high for both cycles, and `done` pulses in the second one. Memory is reached through a single-port word interface whose read data arrives one cycle after the request.

Top module: `stack_unit`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0, the stack pointer (register 13) holds `SP_INIT`, and every other register holds 0.
- R2: In the cycle after a push is accepted, the stack pointer is lowered by exactly one. The new value is visible on `sp_value` from the second cycle of the push.
- R3: In the second cycle of a push, `mem_req`=1 and `mem_we`=1, `mem_addr` equals the lowered stack pointer, and `mem_wdata` equals the pushed value. That word is in memory once the push ends.
- R4: A pop reads memory at the current stack pointer (`mem_req`=1, `mem_we`=0), writes the returned word to the register selected by `pop_idx`, and raises the stack pointer by one.
- R5: When a pop targets register 13, the stack pointer takes the loaded word, and the increment is discarded.
- R6: `busy` is 1 for exactly the two cycles after a request is accepted. `done` is 1 only in the second of those cycles, and it never stays high for two cycles in a row.
- R7: A request raised while `busy`=1 is ignored. It changes neither the stack pointer, memory nor any register.
- R8: If `push_req` and `pop_req` are both high in the same idle cycle, only the push is carried out.
- R9: Two pushes followed by one pop leave the stack pointer one below its starting value, and the popped word is the second value pushed.
- R10: Stack pointer arithmetic wraps modulo 2^32. A push at pointer 0 uses address 32'hFFFF_FFFF, and a pop there returns the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request a push of `push_data` |
| push_data | input | 32 | Resolved value to push |
| pop_req | input | 1 | Request a pop into register `pop_idx` |
| pop_idx | input | 4 | Target register of a pop |
| busy | output | 1 | Operation in progress; new requests ignored |
| done | output | 1 | One-cycle pulse in the last cycle of an operation |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rd_idx | input | 4 | Register file observation index |
| rd_data | output | 32 | Contents of register `rd_idx` |
| sp_value | output | 32 | Current stack pointer (register 13) |

## Verification
The main function is tried with a table of interleaved pushes and pops:
- a plain push-push-pop run, which separates correct last-in-first-out ordering from a queue or a wrong pointer direction;
- pops into registers 0 and 15, which expose index decoding faults at both ends of the file;
- an all-zero word, which is only distinguishable from a lost write because memory was seeded differently.

Directed cases then cover the remaining behaviours:
- a pop into the pointer register, which tells load priority apart from increment priority;
- a push at pointer 0, which shows wraparound;
- requests raised during `busy` and a simultaneous push and pop, which reveal whether a request slipped through or the wrong operation won.

// File: rtl/stack_pkg.sv
package stack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_DEC,
        ST_PUSH_WR,
        ST_POP_RD,
        ST_POP_WB
    } stk_state_e;

endpackage

// File: rtl/stack_regfile.sv
module stack_regfile #(
    parameter int              DATA_W = 32,
    parameter int              NREG   = 16,
    parameter int              SP_IDX = 13,
    parameter logic [DATA_W-1:0] SP_INIT = 32'h0000_0100,
    localparam int             IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sp_we,
    input  logic [DATA_W-1:0] sp_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sp_o
);

    typedef logic [DATA_W-1:0] word_t;

    word_t regs_d [NREG];
    word_t regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (sp_we) begin
            regs_d[SP_IDX] = sp_wdata;
        end
        // a data write comes last so a load into the pointer register wins
        if (wr_en) begin
            regs_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                regs_q[k] <= (k == SP_IDX) ? SP_INIT : '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = regs_q[rd_idx];
    assign sp_o    = regs_q[SP_IDX];

endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
    import stack_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic [IDX_W-1:0]  pop_idx,
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wdata
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        stk_state_e          st;
        logic [DATA_W-1:0]   data;
        logic [IDX_W-1:0]    idx;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        busy      = (c_q.st != ST_IDLE);
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp_i;
        mem_wdata = c_q.data;
        rf_we     = 1'b0;
        rf_idx    = c_q.idx;
        rf_wdata  = mem_rdata;
        sp_we     = 1'b0;
        sp_wdata  = sp_i;
        unique case (c_q.st)
            ST_IDLE: begin
                if (push_req) begin
                    c_d.st   = ST_PUSH_DEC;
                    c_d.data = push_data;
                end else if (pop_req) begin
                    c_d.st  = ST_POP_RD;
                    c_d.idx = pop_idx;
                end
            end
            ST_PUSH_DEC: begin
                sp_we    = 1'b1;
                sp_wdata = sp_i - ONE;
                c_d.st   = ST_PUSH_WR;
            end
            ST_PUSH_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                done    = 1'b1;
                c_d.st  = ST_IDLE;
            end
            ST_POP_RD: begin
                mem_req = 1'b1;
                c_d.st  = ST_POP_WB;
            end
            ST_POP_WB: begin
                rf_we    = 1'b1;
                sp_we    = 1'b1;
                sp_wdata = sp_i + ONE;
                done     = 1'b1;
                c_d.st   = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, data: '0, idx: '0};
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
    parameter int                DATA_W  = 32,
    parameter int                NREG    = 16,
    parameter int                SP_IDX  = 13,
    parameter logic [DATA_W-1:0] SP_INIT = 32'h0000_0100,
    localparam int               IDX_W   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic [IDX_W-1:0]  pop_idx,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sp_value
);

    logic              rf_we;
    logic [IDX_W-1:0]  rf_idx;
    logic [DATA_W-1:0] rf_wdata;
    logic              sp_we;
    logic [DATA_W-1:0] sp_wdata;
    logic [DATA_W-1:0] sp_q;

    stack_ctrl #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_data (push_data),
        .pop_req   (pop_req),
        .pop_idx   (pop_idx),
        .sp_i      (sp_q),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rf_we     (rf_we),
        .rf_idx    (rf_idx),
        .rf_wdata  (rf_wdata),
        .sp_we     (sp_we),
        .sp_wdata  (sp_wdata)
    );

    stack_regfile #(
        .DATA_W  (DATA_W),
        .NREG    (NREG),
        .SP_IDX  (SP_IDX),
        .SP_INIT (SP_INIT)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_idx   (rf_idx),
        .wr_data  (rf_wdata),
        .sp_we    (sp_we),
        .sp_wdata (sp_wdata),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .sp_o     (sp_q)
    );

    assign sp_value = sp_q;

endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
    parameter int                DATA_W  = 32,
    parameter int                IDX_W   = 4,
    parameter int                SP_IDX  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              busy,
    input  logic              done,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_addr,
    input  logic              rf_we,
    input  logic [IDX_W-1:0]  rf_idx,
    input  logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] sp_q
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (push_req || pop_req)) |=> busy);

    // R3
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == $past(sp_q) - ONE));

    // R4
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && (rf_idx != IDX_W'(SP_IDX))) |=> (sp_q == $past(sp_q) + ONE));

    // R5
    pop_sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && (rf_idx == IDX_W'(SP_IDX))) |=> (sp_q == $past(rf_wdata)));

endmodule

bind stack_unit stack_unit_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .SP_IDX (SP_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rf_we    (rf_we),
    .rf_idx   (rf_idx),
    .rf_wdata (rf_wdata),
    .sp_q     (sp_q)
);

// File: tb/stack_unit_test.sv
module stack_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop_req = 1'b0;
    logic [3:0]  pop_idx = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, rd_data, sp_value;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  rd_idx = '0;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [31:0] mem [1024];

    always #5 clk = ~clk;

    stack_unit uut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_idx(pop_idx), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rd_idx(rd_idx),
        .rd_data(rd_data), .sp_value(sp_value)
    );

    // synchronous single-port word memory, read data one cycle later
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    typedef struct packed {
        logic        is_push;
        logic [3:0]  idx;
        logic [31:0] data;
        logic [31:0] exp_val;
        logic [31:0] exp_sp;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1'b1, 4'd0,  32'h1111_1111, 32'h1111_1111, 32'h0000_00FF},
        '{1'b1, 4'd0,  32'h2222_2222, 32'h2222_2222, 32'h0000_00FE},
        '{1'b0, 4'd3,  32'h0,         32'h2222_2222, 32'h0000_00FF},
        '{1'b1, 4'd0,  32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_00FE},
        '{1'b0, 4'd0,  32'h0,         32'hDEAD_BEEF, 32'h0000_00FF},
        '{1'b0, 4'd15, 32'h0,         32'h1111_1111, 32'h0000_0100},
        '{1'b1, 4'd0,  32'h0,         32'h0,         32'h0000_00FF},
        '{1'b0, 4'd7,  32'h0,         32'h0,         32'h0000_0100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] i, output logic [31:0] v);
        rd_idx = i;
        #1;
        v = rd_data;
    endtask

    // raise a request for one cycle; returns at the negedge of the first busy cycle
    task automatic start_op(input logic is_push, input logic [31:0] d, input logic [3:0] i);
        @(negedge clk);
        push_req  = is_push;
        pop_req   = !is_push;
        push_data = d;
        pop_idx   = i;
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        @(negedge clk);
    endtask

    logic [31:0] v;

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = 32'h5555_0000 + a;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 sp", sp_value, 32'h0000_0100);
        read_reg(4'd5, v);
        chk("R1 reg5", v, 32'd0);
        rst_n = 1'b1;

        // table of pushes and pops
        for (int n = 0; n < 8; n++) begin
            start_op(TBL[n].is_push, TBL[n].data, TBL[n].idx);
            finish_op();
            if (TBL[n].is_push) begin
                chk("R3 table memory", mem[TBL[n].exp_sp[9:0]], TBL[n].exp_val);
                chk("R2 table sp", sp_value, TBL[n].exp_sp);
            end else begin
                read_reg(TBL[n].idx, v);
                chk("R4 table register", v, TBL[n].exp_val);
                chk("R4 table sp", sp_value, TBL[n].exp_sp);
            end
            if (n == 2) chk("R9 sp one below start", sp_value, 32'h0000_00FF);
        end

        // R2 R3 R6 cycle-level push
        start_op(1'b1, 32'hA5A5_A5A5, 4'd0);
        chk("R6 busy cycle1", {31'b0, busy}, 32'd1);
        chk("R6 done cycle1", {31'b0, done}, 32'd0);
        @(negedge clk);
        chk("R2 sp lowered", sp_value, 32'h0000_00FF);
        chk("R6 done cycle2", {31'b0, done}, 32'd1);
        chk("R3 we", {30'b0, mem_req, mem_we}, 32'd3);
        chk("R3 addr", mem_addr, 32'h0000_00FF);
        chk("R3 wdata", mem_wdata, 32'hA5A5_A5A5);
        @(negedge clk);
        chk("R6 idle after", {30'b0, busy, done}, 32'd0);

        // R4 cycle-level pop
        start_op(1'b0, 32'h0, 4'd9);
        chk("R4 read req", {30'b0, mem_req, mem_we}, 32'd2);
        chk("R4 read addr", mem_addr, 32'h0000_00FF);
        finish_op();
        read_reg(4'd9, v);
        chk("R4 pop r9", v, 32'hA5A5_A5A5);
        chk("R4 sp raised", sp_value, 32'h0000_0100);

        // R7 request during busy ignored
        @(negedge clk);
        push_req = 1'b1; push_data = 32'h0BAD_0001;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b1; pop_idx = 4'd2;
        @(negedge clk);
        pop_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 no second op busy", {31'b0, busy}, 32'd0);
        chk("R7 sp", sp_value, 32'h0000_00FF);
        read_reg(4'd2, v);
        chk("R7 reg2 untouched", v, 32'd0);

        // R8 simultaneous push and pop
        @(negedge clk);
        push_req = 1'b1; pop_req = 1'b1; push_data = 32'h0808_0808; pop_idx = 4'd4;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        finish_op();
        chk("R8 sp", sp_value, 32'h0000_00FE);
        chk("R8 memory", mem[10'h0FE], 32'h0808_0808);
        read_reg(4'd4, v);
        chk("R8 reg4 untouched", v, 32'd0);

        // R5 pop into the pointer register
        start_op(1'b1, 32'h0000_0040, 4'd0);
        finish_op();
        start_op(1'b0, 32'h0, 4'd13);
        finish_op();
        chk("R5 sp loaded", sp_value, 32'h0000_0040);

        // R10 wrap at pointer 0
        start_op(1'b1, 32'h0, 4'd0);
        finish_op();
        start_op(1'b0, 32'h0, 4'd13);
        finish_op();
        chk("R5 sp loaded zero", sp_value, 32'h0);
        start_op(1'b1, 32'h0000_CAFE, 4'd0);
        @(negedge clk);
        chk("R10 wrap addr", mem_addr, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R10 sp wrapped", sp_value, 32'hFFFF_FFFF);
        start_op(1'b0, 32'h0, 4'd1);
        finish_op();
        read_reg(4'd1, v);
        chk("R10 popped", v, 32'h0000_CAFE);
        chk("R10 sp back to zero", sp_value, 32'h0);

        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule